// File: doc/BRIEF.md
# Shift-and-Add Arithmetic Unit with Overflow Flags

This purely combinational datapath unit scales its first operand by a left shift of zero to three places and then adds the second operand. A carry-in taken from a status carry bit can be added when enabled. It works either on the full datapath width (wide mode) or on the low half only (narrow mode). The result, the raw adder carry, and two overflow indications are produced in the same evaluation.

The overflow indications cover the whole operation, not only the adder. The signed flag also catches a pre-shift that changes the operand's sign. The unsigned flag also catches significant bits pushed off the top by the shift. Both are computed at the sign position of the active mode.

Two trap request inputs are resolved against those flags. One traps on signed overflow; the other traps on the carry condition, which is judged with the unsigned flag. The unit produces a trap output and a write-back enable. The enable drops whenever a trap fires, so the result is never committed on a trapping operation.

Top module: `sadd_unit`

## Requirements
- R1: In wide mode (`mode64`=1), `sum` equals `(a << shamt) + b + (cin & use_carry)` modulo 2^64.
- R2: In narrow mode (`mode64`=0), only bits 31:0 of `a` and `b` take part, so `sum[31:0]` is the 32-bit result and `sum[63:32]` is zero. `carry_out` is taken from bit 32 of the addition.
- R3: `carry_out` is the carry out of the adder's top bit for the active mode (bit 63 wide, bit 31 narrow). Bits lost by the shift do not affect it.
- R4: `sv` is set when the shifted first addend and the second addend have equal sign bits and the sum's sign bit differs from them.
- R5: `sv` is also set when any of the `shamt` original bits of `a` just below the sign bit (bit 63 wide, bit 31 narrow) differs from the original sign bit.
- R6: `uv` is `carry_out` ORed with any nonzero bit among the `shamt` topmost bits of the active width of the original `a`. With `shamt`=0, `uv` equals `carry_out`.
- R7: When `use_carry`=0, `cin` has no effect on any output.
- R8: `trap` = (`trap_sv` & `sv`) | (`trap_cond` & `uv`).
- R9: `wb_en` is 1 exactly when `trap` is 0.
- R10: In narrow mode, bits 63:32 of `a` and `b` affect no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand, shifted before the add |
| b | input | 64 | Second operand |
| cin | input | 1 | Status carry bit offered as carry-in |
| use_carry | input | 1 | Adds `cin` into the sum when 1 |
| shamt | input | 2 | Pre-shift amount for `a`, 0 to 3 |
| mode64 | input | 1 | 1 = wide (64-bit) operation, 0 = narrow (32-bit) |
| trap_sv | input | 1 | Request a trap on signed overflow |
| trap_cond | input | 1 | Request a trap on the carry condition (unsigned overflow) |
| sum | output | 64 | Result; upper half zero in narrow mode |
| carry_out | output | 1 | Raw adder carry at the active width |
| sv | output | 1 | Signed overflow including the shift |
| uv | output | 1 | Unsigned overflow including the shift |
| trap | output | 1 | Trap request |
| wb_en | output | 1 | Result may be written back |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and a 2-bit shift amount. That puts both sign positions, bit 31 and bit 63, within reach, and it covers every shift from none up to three places. At the widest shift, three bits are lost and three bits below the sign are compared. With these defaults, the vectors separate the adder's own overflow from the shift-induced overflow. They also show narrow mode ignoring the upper operand halves, and they pair each trap request with the flag that should and should not fire it.

// File: rtl/sadd_pkg.sv
`timescale 1ns/1ps
package sadd_pkg;
  // Flags produced by the pre-shift stage for the bits that leave the active width
  typedef struct packed {
    logic sign_lost;   // a bit below the sign differs from it
    logic bits_lost;   // a one was shifted out of the top
  } shift_loss_t;

  // Raw adder outcome at the active width
  typedef struct packed {
    logic carry;
    logic ovf;
  } add_stat_t;
endpackage

// File: rtl/sadd_preshift.sv
`timescale 1ns/1ps
module sadd_preshift
  import sadd_pkg::*;
#(
  parameter int W   = 64,
  parameter int SHW = 2
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] shamt,
  input  logic           mode64,
  output logic [W-1:0]   a_sh,
  output shift_loss_t    loss
);
  localparam int HALF  = W / 2;
  localparam int MAXSH = (1 << SHW) - 1;

  logic [W-1:0]  a_act;
  logic [W-1:0]  a_wide_sh;
  shift_loss_t   lane_loss [2];

  // Narrow mode drops the upper half before anything else sees it
  always_comb begin
    a_act = mode64 ? a : {{HALF{1'b0}}, a[HALF-1:0]};
    a_wide_sh = a_act << shamt;
    a_sh = mode64 ? a_wide_sh : {{HALF{1'b0}}, a_wide_sh[HALF-1:0]};
  end

  // One loss detector per sign position: lane 0 narrow, lane 1 wide
  for (genvar m = 0; m < 2; m++) begin : g_lane
    localparam int SP = (m == 1) ? W - 1 : HALF - 1;
    always_comb begin
      lane_loss[m] = '0;
      for (int i = 1; i <= MAXSH; i++) begin
        if (i <= int'(shamt)) begin
          lane_loss[m].sign_lost = lane_loss[m].sign_lost | (a[SP-i] ^ a[SP]);
          lane_loss[m].bits_lost = lane_loss[m].bits_lost | a[SP-i+1];
        end
      end
    end
  end

  assign loss = mode64 ? lane_loss[1] : lane_loss[0];
endmodule

// File: rtl/sadd_adder.sv
`timescale 1ns/1ps
module sadd_adder
  import sadd_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  input  logic         mode64,
  output logic [W-1:0] s,
  output add_stat_t    stat
);
  localparam int HALF = W / 2;

  logic [W-1:0] y_act;
  logic [W:0]   raw;
  logic         sx, sy, ss;

  always_comb begin
    y_act = mode64 ? y : {{HALF{1'b0}}, y[HALF-1:0]};
    raw   = {1'b0, x} + {1'b0, y_act} + {{W{1'b0}}, ci};
    s     = mode64 ? raw[W-1:0] : {{HALF{1'b0}}, raw[HALF-1:0]};
    if (mode64) begin
      stat.carry = raw[W];
      sx = x[W-1];
      sy = y_act[W-1];
      ss = raw[W-1];
    end else begin
      stat.carry = raw[HALF];
      sx = x[HALF-1];
      sy = y_act[HALF-1];
      ss = raw[HALF-1];
    end
    stat.ovf = (sx == sy) && (ss != sx);
  end
endmodule

// File: rtl/sadd_trap.sv
`timescale 1ns/1ps
module sadd_trap (
  input  logic sv,
  input  logic uv,
  input  logic trap_sv,
  input  logic trap_cond,
  output logic trap,
  output logic wb_en
);
  always_comb begin
    trap  = (trap_sv & sv) | (trap_cond & uv);
    wb_en = ~trap;
  end
endmodule

// File: rtl/sadd_unit.sv
`timescale 1ns/1ps
module sadd_unit
  import sadd_pkg::*;
#(
  parameter int W   = 64,
  parameter int SHW = 2
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  input  logic           use_carry,
  input  logic [SHW-1:0] shamt,
  input  logic           mode64,
  input  logic           trap_sv,
  input  logic           trap_cond,
  output logic [W-1:0]   sum,
  output logic           carry_out,
  output logic           sv,
  output logic           uv,
  output logic           trap,
  output logic           wb_en
);
  logic [W-1:0] a_sh;
  shift_loss_t  loss;
  add_stat_t    stat;

  sadd_preshift #(.W(W), .SHW(SHW)) u_shift (
    .a      (a),
    .shamt  (shamt),
    .mode64 (mode64),
    .a_sh   (a_sh),
    .loss   (loss)
  );

  sadd_adder #(.W(W)) u_add (
    .x      (a_sh),
    .y      (b),
    .ci     (cin & use_carry),
    .mode64 (mode64),
    .s      (sum),
    .stat   (stat)
  );

  assign carry_out = stat.carry;
  assign sv        = stat.ovf | loss.sign_lost;
  assign uv        = stat.carry | loss.bits_lost;

  sadd_trap u_trap (
    .sv        (sv),
    .uv        (uv),
    .trap_sv   (trap_sv),
    .trap_cond (trap_cond),
    .trap      (trap),
    .wb_en     (wb_en)
  );
endmodule

// File: rtl/sadd_unit_chk.sv
`timescale 1ns/1ps
module sadd_unit_chk #(
  parameter int W   = 64,
  parameter int SHW = 2
) (
  input logic [W-1:0]   a,
  input logic [SHW-1:0] shamt,
  input logic           mode64,
  input logic           trap_sv,
  input logic           trap_cond,
  input logic [W-1:0]   sum,
  input logic           carry_out,
  input logic           sv,
  input logic           uv,
  input logic           trap,
  input logic           wb_en
);
  localparam int HALF = W / 2;

  always_comb begin
    a_r6_carry_implies_uv: assert (!carry_out || uv)
      else $error("R6: carry_out set without uv");
    a_r6_noshift_uv: assert (shamt != '0 || uv == carry_out)
      else $error("R6: uv differs from carry with no shift");
    a_r2_upper_zero: assert (mode64 || sum[W-1:HALF] == '0)
      else $error("R2: upper sum bits nonzero in narrow mode");
    a_r5_shift_one_sv: assert (!(mode64 && shamt == 1 && a[W-1] != a[W-2]) || sv)
      else $error("R5: one-place shift changed sign without sv");
    a_r8_sv_trap: assert (!(trap_sv && sv) || trap)
      else $error("R8: signed overflow trap missed");
    a_r8_cond_trap: assert (!(trap_cond && uv) || trap)
      else $error("R8: condition trap missed");
    a_r8_no_request: assert (trap_sv || trap_cond || !trap)
      else $error("R8: trap without request");
    a_r9_wb_blocked: assert (!trap || !wb_en)
      else $error("R9: write-back enabled during trap");
  end
endmodule

bind sadd_unit sadd_unit_chk #(.W(W), .SHW(SHW)) u_chk (
  .a         (a),
  .shamt     (shamt),
  .mode64    (mode64),
  .trap_sv   (trap_sv),
  .trap_cond (trap_cond),
  .sum       (sum),
  .carry_out (carry_out),
  .sv        (sv),
  .uv        (uv),
  .trap      (trap),
  .wb_en     (wb_en)
);

// File: tb/tb_sadd_unit.sv
`timescale 1ns/1ps
module tb_sadd_unit;
  logic        clk;
  logic        rst_n;
  logic [63:0] a, b, sum;
  logic        cin, use_carry, mode64, trap_sv, trap_cond;
  logic [1:0]  shamt;
  logic        carry_out, sv, uv, trap, wb_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sadd_unit dut (
    .a(a), .b(b), .cin(cin), .use_carry(use_carry), .shamt(shamt),
    .mode64(mode64), .trap_sv(trap_sv), .trap_cond(trap_cond),
    .sum(sum), .carry_out(carry_out), .sv(sv), .uv(uv),
    .trap(trap), .wb_en(wb_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        cin;
    logic        uc;
    logic [1:0]  sh;
    logic        m64;
    logic [63:0] sum;
    logic        co;
    logic        sv;
    logic        uv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{64'h1, 64'h2, 1'b0, 1'b0, 2'd0, 1'b1, 64'h3, 1'b0, 1'b0, 1'b0},
    '{64'h3, 64'h5, 1'b0, 1'b0, 2'd2, 1'b1, 64'h11, 1'b0, 1'b0, 1'b0},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 2'd0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 2'd0, 1'b1, 64'h0, 1'b1, 1'b0, 1'b1},
    '{64'h4000_0000_0000_0000, 64'h0, 1'b0, 1'b0, 2'd1, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{64'hC000_0000_0000_0000, 64'h0, 1'b0, 1'b0, 2'd1, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1},
    '{64'h1000_0000_0000_0000, 64'h0, 1'b0, 1'b0, 2'd3, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{64'h0800_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, 1'b0, 2'd3, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{64'h0000_0000_4000_0000, 64'h0, 1'b0, 1'b0, 2'd1, 1'b0, 64'h8000_0000, 1'b0, 1'b1, 1'b0},
    '{64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 2'd0, 1'b0, 64'h0, 1'b1, 1'b0, 1'b1},
    '{64'h7FFF_FFFF, 64'h0, 1'b1, 1'b1, 2'd0, 1'b0, 64'h8000_0000, 1'b0, 1'b1, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1},
    '{64'h2000_0000, 64'h0, 1'b0, 1'b0, 2'd2, 1'b0, 64'h8000_0000, 1'b0, 1'b1, 1'b0},
    '{64'hC000_0000, 64'h0, 1'b0, 1'b0, 2'd1, 1'b0, 64'h8000_0000, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] va, input logic [63:0] vb, input logic vcin,
                       input logic vuc, input logic [1:0] vsh, input logic vm64,
                       input logic vtsv, input logic vtc);
    @(negedge clk);
    a = va; b = vb; cin = vcin; use_carry = vuc; shamt = vsh; mode64 = vm64;
    trap_sv = vtsv; trap_cond = vtc;
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    a = '0; b = '0; cin = 0; use_carry = 0; shamt = '0; mode64 = 0;
    trap_sv = 0; trap_cond = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give quiet outputs and open write-back (R9)
    drive(64'h0, 64'h0, 0, 0, 2'd0, 0, 0, 0);
    check("R2 idle sum", sum, 64'h0);
    check("R6 idle uv", {63'h0, uv}, 64'h0);
    check("R9 idle wb_en", {63'h0, wb_en}, 64'h1);

    // Vector table: R1 R2 sum, R3 carry, R4 R5 sv, R6 uv
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].a, VECS[i].b, VECS[i].cin, VECS[i].uc, VECS[i].sh, VECS[i].m64, 0, 0);
      check($sformatf("R1 R2 sum vec%0d", i), sum, VECS[i].sum);
      check($sformatf("R3 carry vec%0d", i), {63'h0, carry_out}, {63'h0, VECS[i].co});
      check($sformatf("R4 R5 sv vec%0d", i), {63'h0, sv}, {63'h0, VECS[i].sv});
      check($sformatf("R6 uv vec%0d", i), {63'h0, uv}, {63'h0, VECS[i].uv});
    end

    // R7: cin offered but not enabled leaves the sum and flags untouched
    drive(64'h7FFF_FFFF, 64'h0, 1, 0, 2'd0, 0, 0, 0);
    check("R7 sum", sum, 64'h7FFF_FFFF);
    check("R7 sv", {63'h0, sv}, 64'h0);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, 0, 2'd0, 1, 0, 0);
    check("R7 carry", {63'h0, carry_out}, 64'h0);

    // R10: upper halves ignored in narrow mode
    drive(64'hDEAD_BEEF_0000_0002, 64'hAAAA_0000_0000_0003, 0, 0, 2'd1, 0, 0, 0);
    check("R10 sum", sum, 64'h7);
    check("R10 flags", {62'h0, sv, uv}, 64'h0);

    // R8 R9: trap resolution
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 2'd0, 1, 1, 0);
    check("R8 sv trap", {63'h0, trap}, 64'h1);
    check("R9 wb blocked", {63'h0, wb_en}, 64'h0);
    drive(64'h1, 64'h2, 0, 0, 2'd0, 1, 1, 1);
    check("R8 no flag no trap", {63'h0, trap}, 64'h0);
    check("R9 wb open", {63'h0, wb_en}, 64'h1);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 2'd0, 1, 0, 1);
    check("R8 cond trap on carry", {63'h0, trap}, 64'h1);
    drive(64'h4000_0000_0000_0000, 64'h0, 0, 0, 2'd1, 1, 0, 1);
    check("R8 cond ignores sv", {63'h0, trap}, 64'h0);
    drive(64'hC000_0000_0000_0000, 64'h0, 0, 0, 2'd1, 1, 1, 0);
    check("R8 sv ignores uv", {63'h0, trap}, 64'h0);
    drive(64'hC000_0000_0000_0000, 64'h0, 0, 0, 2'd1, 1, 0, 1);
    check("R8 cond trap on shift loss", {63'h0, trap}, 64'h1);

    done = 1;
    finish_run();
  end
endmodule